// File: doc/BRIEF.md
# Staged Crosspoint Routing Switch

This block routes eight single-bit data inputs onto eight data outputs. Every output has its own selector that can pick any input, and any input may feed any number of outputs at once. An output can instead be switched off. It then drives 0 and drops its enable flag, and a pad ring or a wired bus uses that flag in place of a real high-impedance state.

Routing is held in two ranks of per-output entries. Each entry holds a 3-bit input number and a disable flag. Software fills the staging rank one output at a time by pulsing a write strobe with an output address, an input address and a disable bit. A single commit strobe then copies the whole staging rank into the active rank, so a new routing plan is prepared in the background and takes effect in one clock. A clear strobe puts both ranks into one of two known states, chosen by the disable bit: every output fed from input 0, or every output off. All three strobes are sampled on the system clock, act on their rising edge only, and are ignored while chip select is low. The data path from input to output is combinational, so outputs whose routing does not change keep passing data across a commit.

Top module: `xp_crosspoint_ctrl`

## Requirements
- R1: After the synchronous active-low reset, every entry in both ranks is disabled: all `out_en` bits are 0 and all `data_out` bits are 0.
- R2: Addresses are plain binary with bit 2 as MSB: `dst_addr` value k selects output k and `src_addr` value k selects input k (e.g. `dst_addr`=3'b001 is output 1, `src_addr`=3'b110 is input 6).
- R3: A write-strobe rising edge with chip select high stores `src_addr` and `off_bit` into the staging entry of output `dst_addr` and leaves the active routing, and therefore `out_en` and `data_out`, unchanged.
- R4: A commit-strobe rising edge with chip select high copies all eight staging entries into the active rank on the same clock edge.
- R5: An active entry whose disable flag is 1 gives `out_en`[k]=0 and `data_out`[k]=0; with the flag 0 it gives `out_en`[k]=1 and `data_out`[k]=`data_in`[selected input].
- R6: A clear-strobe rising edge with chip select high and `off_bit`=0 sets every entry of both ranks to input 0, enabled.
- R7: A clear-strobe rising edge with chip select high and `off_bit`=1 sets every entry of both ranks to disabled.
- R8: While `chip_sel` is 0, edges on the write, commit and clear strobes change no state.
- R9: A strobe acts only in the clock where it is first seen high after being low; holding it high while the addresses change does not act again.
- R10: When several strobes rise in the same clock, only one acts, in the priority clear over commit over write; the lower ones are discarded.
- R11: `data_out` follows `data_in` within the same cycle, without a register, so an output whose routing a commit leaves unchanged shows no gap.
- R12: One input may drive several or all outputs at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; disables all routing |
| data_in | input | 8 | Data inputs, bit k is input k |
| src_addr | input | 3 | Input number written into a staging entry |
| dst_addr | input | 3 | Output whose staging entry is written |
| off_bit | input | 1 | Disable flag for a write; selects the clear mode |
| chip_sel | input | 1 | Enables the three strobes when high |
| load_strobe | input | 1 | Write strobe, rising edge active |
| cfg_strobe | input | 1 | Commit strobe, rising edge active |
| clear_strobe | input | 1 | Clear strobe, rising edge active |
| data_out | output | 8 | Routed data, 0 on a disabled output |
| out_en | output | 8 | Output enable flags, 1 when the output is driven |

## Verification
The hardest case to reach is two or three strobes rising in the same clock. The dropped lower-priority action leaves nothing visible until a later commit shows the staging rank, so the bench pairs commit and write in one cycle and then commits again to show that the write was discarded. A strobe held high while the addresses change is driven directly, because random single-cycle pulses never produce it. Random write, commit and clear traffic, with chip select sometimes low, is compared after every step against a two-rank model in the bench.

// File: rtl/xp_pkg.sv
// Shared types for the crosspoint routing controller.
// Assumes: at most one rank action per clock, chosen by fixed priority.
package xp_pkg;

    typedef enum logic [1:0] {
        XP_IDLE   = 2'd0,
        XP_WRITE  = 2'd1,
        XP_COMMIT = 2'd2,
        XP_CLEAR  = 2'd3
    } xp_act_e;

    // Priority pick: clear beats commit, commit beats write.
    function automatic xp_act_e xp_pick(input logic clr, input logic cmt, input logic wr);
        if (clr)      return XP_CLEAR;
        else if (cmt) return XP_COMMIT;
        else if (wr)  return XP_WRITE;
        else          return XP_IDLE;
    endfunction

endpackage

// File: rtl/xp_edge_detect.sv
// Rising-edge detector for a group of level strobes sampled on clk.
// Assumes: strobes are synchronous to clk; a strobe high during reset
// counts as a new edge in the first clock after reset.
module xp_edge_detect #(
    parameter int NUM_SIG = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] level,
    output logic [NUM_SIG-1:0] rise
);

    logic [NUM_SIG-1:0] prev_q;

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_bit
        // Remember last sampled level of this strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= level[i];
        end
        // First high sample after a low one.
        assign rise[i] = level[i] & ~prev_q[i];
    end

endmodule

// File: rtl/xp_ctrl_decode.sv
// Turns gated strobe edges into one rank action per clock.
// Assumes: rise bits ordered {clear, commit, write}.
module xp_ctrl_decode
    import xp_pkg::*;
(
    input  logic       chip_sel,
    input  logic [2:0] rise,
    output xp_act_e    act
);

    // Gate with chip select, then apply fixed priority.
    always_comb begin
        if (chip_sel) act = xp_pick(rise[2], rise[1], rise[0]);
        else          act = XP_IDLE;
    end

endmodule

// File: rtl/xp_route_bank.sv
// Two ranks of per-output routing entries: staging and active.
// Each entry is an input number plus a disable flag.
// Assumes: act is already priority-resolved; reset leaves everything off.
module xp_route_bank
    import xp_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  xp_act_e                           act,
    input  logic [$clog2(NUM_IN)-1:0]         src_addr,
    input  logic [$clog2(NUM_OUT)-1:0]        dst_addr,
    input  logic                              off_bit,
    output logic [NUM_OUT*$clog2(NUM_IN)-1:0] act_sel,
    output logic [NUM_OUT-1:0]                act_off
);

    localparam int SEL_W = $clog2(NUM_IN);
    localparam int DST_W = $clog2(NUM_OUT);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_entry
        logic [SEL_W-1:0] stg_sel_q;
        logic             stg_off_q;
        logic [SEL_W-1:0] act_sel_q;
        logic             act_off_q;
        logic             hit;

        assign hit = (dst_addr == DST_W'(k));

        // Staging entry: cleared, or written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_sel_q <= '0;
                stg_off_q <= 1'b1;
            end else begin
                unique case (act)
                    XP_CLEAR: begin
                        stg_sel_q <= '0;
                        stg_off_q <= off_bit;
                    end
                    XP_WRITE: begin
                        if (hit) begin
                            stg_sel_q <= src_addr;
                            stg_off_q <= off_bit;
                        end
                    end
                    default: ;
                endcase
            end
        end

        // Active entry: cleared, or loaded from staging on commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_sel_q <= '0;
                act_off_q <= 1'b1;
            end else begin
                unique case (act)
                    XP_CLEAR: begin
                        act_sel_q <= '0;
                        act_off_q <= off_bit;
                    end
                    XP_COMMIT: begin
                        act_sel_q <= stg_sel_q;
                        act_off_q <= stg_off_q;
                    end
                    default: ;
                endcase
            end
        end

        assign act_sel[k*SEL_W +: SEL_W] = act_sel_q;
        assign act_off[k]                = act_off_q;
    end

endmodule

// File: rtl/xp_out_mux.sv
// Per-output selectors driven by the active rank.
// Assumes: purely combinational so data is never held up by a commit.
module xp_out_mux #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic [NUM_IN-1:0]                 data_in,
    input  logic [NUM_OUT*$clog2(NUM_IN)-1:0] act_sel,
    input  logic [NUM_OUT-1:0]                act_off,
    output logic [NUM_OUT-1:0]                data_out,
    output logic [NUM_OUT-1:0]                out_en
);

    localparam int SEL_W = $clog2(NUM_IN);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_sel
        logic [SEL_W-1:0] sel;
        assign sel = act_sel[k*SEL_W +: SEL_W];

        // Pick the chosen input, force 0 when the output is off.
        always_comb begin
            out_en[k]   = ~act_off[k];
            data_out[k] = act_off[k] ? 1'b0 : data_in[sel];
        end
    end

endmodule

// File: rtl/xp_crosspoint_ctrl.sv
// Top of the staged crosspoint: edge detection, action decode,
// two-rank routing store and output selectors.
// Assumes: all control inputs synchronous to clk.
module xp_crosspoint_ctrl
    import xp_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IN-1:0]          data_in,
    input  logic [$clog2(NUM_IN)-1:0]  src_addr,
    input  logic [$clog2(NUM_OUT)-1:0] dst_addr,
    input  logic                       off_bit,
    input  logic                       chip_sel,
    input  logic                       load_strobe,
    input  logic                       cfg_strobe,
    input  logic                       clear_strobe,
    output logic [NUM_OUT-1:0]         data_out,
    output logic [NUM_OUT-1:0]         out_en
);

    localparam int SEL_W = $clog2(NUM_IN);

    logic [2:0]               rise;
    xp_act_e                  act;
    logic [NUM_OUT*SEL_W-1:0] act_sel;
    logic [NUM_OUT-1:0]       act_off;

    xp_edge_detect #(.NUM_SIG(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({clear_strobe, cfg_strobe, load_strobe}),
        .rise  (rise)
    );

    xp_ctrl_decode u_dec (
        .chip_sel (chip_sel),
        .rise     (rise),
        .act      (act)
    );

    xp_route_bank #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .off_bit  (off_bit),
        .act_sel  (act_sel),
        .act_off  (act_off)
    );

    xp_out_mux #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_mux (
        .data_in  (data_in),
        .act_sel  (act_sel),
        .act_off  (act_off),
        .data_out (data_out),
        .out_en   (out_en)
    );

endmodule

// File: rtl/xp_route_checker.sv
// Port-level properties of the crosspoint, bound to the top module.
module xp_route_checker #(
    parameter int NUM_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chip_sel,
    input logic               off_bit,
    input logic               load_strobe,
    input logic               cfg_strobe,
    input logic               clear_strobe,
    input logic [NUM_OUT-1:0] data_out,
    input logic [NUM_OUT-1:0] out_en
);

    // R1: first clock out of reset still shows everything disabled.
    assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_en == '0));

    // R8: no chip select, no change of enables.
    assert_cs_low_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |=> $stable(out_en));

    // R3: a lone write edge leaves active routing alone.
    assert_write_staged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && $rose(load_strobe) && !$rose(cfg_strobe) && !$rose(clear_strobe))
        |=> $stable(out_en));

    // R7: clear in disable mode turns every output off.
    assert_clear_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && $rose(clear_strobe) && off_bit) |=> (out_en == '0));

    // R6: clear in broadcast mode enables every output.
    assert_clear_bcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && $rose(clear_strobe) && !off_bit) |=> (&out_en));

    // R5: a disabled output never carries a 1.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_quiet
        assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> !data_out[k]);
    end

endmodule

bind xp_crosspoint_ctrl xp_route_checker #(.NUM_OUT(NUM_OUT)) u_route_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_sel     (chip_sel),
    .off_bit      (off_bit),
    .load_strobe  (load_strobe),
    .cfg_strobe   (cfg_strobe),
    .clear_strobe (clear_strobe),
    .data_out     (data_out),
    .out_en       (out_en)
);

// File: tb/xp_crosspoint_ctrl_bench.sv
`timescale 1ns/1ps
module xp_crosspoint_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = '0;
    logic [2:0] src_addr = '0;
    logic [2:0] dst_addr = '0;
    logic       off_bit = 1'b0;
    logic       chip_sel = 1'b0;
    logic       load_strobe = 1'b0;
    logic       cfg_strobe = 1'b0;
    logic       clear_strobe = 1'b0;
    logic [7:0] data_out;
    logic [7:0] out_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model: staging and active ranks.
    logic [2:0] m_ss [8];
    logic       m_so [8];
    logic [2:0] m_as [8];
    logic       m_ao [8];

    always #2 clk = ~clk;

    xp_crosspoint_ctrl u_xp_crosspoint_ctrl (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .src_addr(src_addr),
        .dst_addr(dst_addr), .off_bit(off_bit), .chip_sel(chip_sel),
        .load_strobe(load_strobe), .cfg_strobe(cfg_strobe),
        .clear_strobe(clear_strobe), .data_out(data_out), .out_en(out_en)
    );

    function automatic logic [7:0] exp_en();
        logic [7:0] e;
        for (int k = 0; k < 8; k++) e[k] = ~m_ao[k];
        return e;
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] din);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) d[k] = m_ao[k] ? 1'b0 : din[m_as[k]];
        return d;
    endfunction

    // Model one clock with the given rising edges.
    task automatic model_step(input bit ld, input bit cf, input bit cl, input bit cs,
                              input logic [2:0] src, input logic [2:0] dst, input bit off);
        if (!cs) return;
        if (cl) begin
            for (int k = 0; k < 8; k++) begin
                m_ss[k] = 3'd0; m_so[k] = off; m_as[k] = 3'd0; m_ao[k] = off;
            end
        end else if (cf) begin
            for (int k = 0; k < 8; k++) begin
                m_as[k] = m_ss[k]; m_ao[k] = m_so[k];
            end
        end else if (ld) begin
            m_ss[dst] = src; m_so[dst] = off;
        end
    endtask

    // Compare outputs with the model under a few data patterns.
    task automatic check(input string req);
        for (int p = 0; p < 3; p++) begin
            data_in = (p == 0) ? 8'hFF : 8'($urandom);
            #0.5;
            total++;
            if (out_en !== exp_en() || data_out !== exp_data(data_in)) begin
                bad++;
                $display("FAIL %s: en=%b data=%b expected en=%b data=%b (din=%b)",
                         req, out_en, data_out, exp_en(), exp_data(data_in), data_in);
            end
        end
    endtask

    // One-cycle strobe pulse; model updated for the following edge.
    task automatic apply(input bit ld, input bit cf, input bit cl, input bit cs,
                         input logic [2:0] src, input logic [2:0] dst, input bit off);
        @(negedge clk);
        load_strobe = ld; cfg_strobe = cf; clear_strobe = cl;
        chip_sel = cs; src_addr = src; dst_addr = dst; off_bit = off;
        model_step(ld, cf, cl, cs, src, dst, off);
        @(negedge clk);
        load_strobe = 0; cfg_strobe = 0; clear_strobe = 0;
    endtask

    initial begin
        #(4.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int k = 0; k < 8; k++) begin
            m_ss[k] = 0; m_so[k] = 1; m_as[k] = 0; m_ao[k] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset all disabled");

        // R2, R3: write output 1 from input 6, active untouched
        apply(1, 0, 0, 1, 3'b110, 3'b001, 0);
        check("R3 write leaves active rank");
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R2 out1 from in6 after commit R4");

        // R12: input 5 to every output
        for (int k = 0; k < 8; k++) apply(1, 0, 0, 1, 3'd5, 3'(k), 0);
        check("R3 staged fanout not visible");
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R12 input 5 on all outputs R4");

        // R5: disable output 2
        apply(1, 0, 0, 1, 3'd4, 3'd2, 1);
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R5 output 2 disabled");

        // R8: chip select low ignores everything
        apply(1, 0, 0, 0, 3'd1, 3'd0, 0);
        apply(0, 1, 0, 0, 0, 0, 0);
        apply(0, 0, 1, 0, 0, 0, 1);
        check("R8 strobes ignored with chip_sel low");
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R8 staging untouched with chip_sel low");

        // R6: broadcast clear, then commit keeps broadcast
        apply(0, 0, 1, 1, 3'd3, 3'd3, 0);
        check("R6 broadcast from input 0");
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R6 staging also broadcast");

        // R7: disabling clear
        apply(0, 0, 1, 1, 0, 0, 1);
        check("R7 all outputs off");
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R7 staging also off");

        // R9: write strobe held high while addresses change
        @(negedge clk);
        chip_sel = 1; load_strobe = 1; src_addr = 3'd3; dst_addr = 3'd4; off_bit = 0;
        model_step(1, 0, 0, 1, 3'd3, 3'd4, 0);
        @(negedge clk);
        src_addr = 3'd7; dst_addr = 3'd5;
        @(negedge clk);
        src_addr = 3'd2; dst_addr = 3'd6;
        @(negedge clk);
        load_strobe = 0;
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R9 held strobe acts once");

        // R10: all three rise together -> clear only
        apply(1, 1, 1, 1, 3'd6, 3'd1, 0);
        check("R10 clear wins over commit and write");
        apply(1, 0, 0, 1, 3'd2, 3'd0, 0);
        apply(1, 1, 0, 1, 3'd7, 3'd0, 0);
        check("R10 commit wins over write");
        apply(0, 1, 0, 1, 0, 0, 0);
        check("R10 dropped write absent from staging");

        // R11: outputs with unchanged routing pass data around a commit
        apply(1, 0, 0, 1, 3'd6, 3'd3, 0);
        @(negedge clk);
        cfg_strobe = 1; chip_sel = 1;
        check("R11 data before commit edge");
        model_step(0, 1, 0, 1, 0, 0, 0);
        @(negedge clk);
        cfg_strobe = 0;
        check("R11 data right after commit edge");

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            bit ld, cf, cl, cs;
            r  = $urandom_range(0, 99);
            ld = (r < 60) || (r > 96);
            cf = (r >= 60 && r < 85) || (r > 97);
            cl = (r >= 85 && r < 90) || (r == 99);
            cs = ($urandom_range(0, 9) != 0);
            apply(ld, cf, cl, cs, 3'($urandom), 3'($urandom), bit'($urandom_range(0, 3) == 0));
            check("R4 random traffic");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule